// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a run of 16-bit words from a three-wire serial EEPROM. The host raises `req` for one cycle with a start word address and a word count. The block then turns the serial interface on and reads each word as a complete transaction: it selects the device, sends a read command and the word address, and clocks in sixteen data bits. It then releases the select line and moves on to the next address. Each finished word appears on `word_data` with a one-cycle `word_valid` strobe. After the last word the interface is turned off and `done` pulses for one cycle.

All serial pins are decoded from the state register. Every pin step lasts exactly `HALF_CLKS` system clocks. An internal step timer paces the steps, and its expiry acts as the ready indication that lets the controller advance. The states are IDLE, ENABLE, SELECT, CMD_SET, CMD_RISE, CMD_FALL, DAT_RISE, DAT_FALL, DESEL and DISABLE. The transitions are:

- IDLE goes to ENABLE on an accepted request with a count above zero.
- ENABLE goes to SELECT.
- SELECT goes to CMD_SET.
- CMD_SET, CMD_RISE and CMD_FALL repeat for each of the nine command bits, then CMD_FALL goes to DAT_RISE.
- DAT_RISE and DAT_FALL repeat sixteen times, then DAT_FALL goes to DESEL.
- DESEL goes back to SELECT while words remain, and otherwise to DISABLE.
- DISABLE goes to IDLE and raises `done`.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, `busy`, `link_en`, `ee_cs`, `ee_sk`, `ee_di`, `word_valid` and `done` are all low.
- R2: `link_en` rises on the cycle after an accepted request, one full step before `ee_cs` first rises, and `link_en` is low again by the time `done` is seen; `ee_cs` is never high while `link_en` is low.
- R3: For every word, `ee_cs` rises while `ee_sk` is low, then nine command bits are sent MSB first: the read opcode binary 110 followed by the 6-bit word address MSB first. Each bit is placed on `ee_di` with `ee_sk` low, then `ee_sk` rises, then falls. `ee_di` never changes while `ee_sk` is high.
- R4: Sixteen data bits are captured MSB first, each taken from `ee_dout` at the end of an `ee_sk`-high step. The word is presented on `word_data` with `word_valid` high for exactly one cycle, and `word_valid` is only ever high while `busy` is high.
- R5: `ee_cs` drops after each word. For a multi-word request the address advances by one per word, modulo 64, and the full select, opcode and address sequence repeats.
- R6: Every pin step holds for `HALF_CLKS` clocks, so a request for N words keeps `busy` high for exactly (61·N + 2)·`HALF_CLKS` cycles.
- R7: A request that arrives while `busy` is high is ignored: the words read, the addresses sent and the run length are those of the request that was first accepted.
- R8: `done` is a single-cycle pulse on the first idle cycle after the last word, and `busy` is low in that cycle.
- R9: A request with a word count of zero produces a `done` pulse on the next cycle, with no activity on the serial pins and `busy` remaining low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle read request, accepted only when idle |
| start_addr | input | ADDR_W | First word address |
| word_cnt | input | CNT_W | Number of words to read |
| busy | output | 1 | High while a request is in progress |
| link_en | output | 1 | Serial interface enable |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_dout | input | 1 | Serial data from the EEPROM |
| word_data | output | DATA_W | Last word read |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench attaches a behavioural EEPROM whose contents are a function of the address. It reads a single word, then a four-word run, then a run that crosses from address 63 back to 0. Comparing these three separates a correct address increment from a stuck or unwrapped one, and correct MSB-first capture from bit reversal. A second request issued in the middle of a read shows whether busy requests leak into the address stream. A zero-count request isolates the early-completion path from the normal pin sequence. For every run, the opcode and address decoded by the model, the exact `busy` duration and the single `done` pulse are compared with values computed from the requirements.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_SELECT,
        ST_CMD_SET,
        ST_CMD_RISE,
        ST_CMD_FALL,
        ST_DAT_RISE,
        ST_DAT_FALL,
        ST_DESEL,
        ST_DISABLE
    } ewr_state_t;

    localparam int unsigned EWR_OPC_W          = 3;
    localparam logic [EWR_OPC_W-1:0] EWR_RD_OPC = 3'b110;

endpackage

// File: rtl/ewr_step_timer.sv
module ewr_step_timer #(
    parameter int unsigned HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step
);
    localparam int unsigned TW = $clog2(HALF_CLKS + 1);
    localparam logic [TW-1:0] RELOAD = TW'(HALF_CLKS - 1);

    logic [TW-1:0] cnt_q;

    assign step = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!run || step) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ewr_seq.sv
module ewr_seq
    import ewr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OPC_W  = EWR_OPC_W,
    parameter logic [OPC_W-1:0] RD_OPC = EWR_RD_OPC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              ee_dout,
    output logic              busy,
    output logic              link_en,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              done
);
    localparam int unsigned CMD_W = OPC_W + ADDR_W;
    localparam int unsigned MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int unsigned BIT_W = $clog2(MAXB);
    localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] DAT_LAST = BIT_W'(DATA_W - 1);

    ewr_state_t         state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   left_q;
    logic [BIT_W-1:0]   bidx_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [CMD_W-1:0]   cmd_vec;

    assign cmd_vec = {RD_OPC, addr_q};

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            left_q     <= '0;
            bidx_q     <= '0;
            shreg_q    <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            done       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        if (word_cnt == '0) begin
                            done <= 1'b1;
                        end else begin
                            addr_q  <= start_addr;
                            left_q  <= word_cnt;
                            state_q <= ST_ENABLE;
                        end
                    end
                end
                ST_ENABLE: if (step) state_q <= ST_SELECT;
                ST_SELECT: begin
                    if (step) begin
                        bidx_q  <= '0;
                        state_q <= ST_CMD_SET;
                    end
                end
                ST_CMD_SET:  if (step) state_q <= ST_CMD_RISE;
                ST_CMD_RISE: if (step) state_q <= ST_CMD_FALL;
                ST_CMD_FALL: begin
                    if (step) begin
                        if (bidx_q == CMD_LAST) begin
                            bidx_q  <= '0;
                            state_q <= ST_DAT_RISE;
                        end else begin
                            bidx_q  <= bidx_q + 1'b1;
                            state_q <= ST_CMD_SET;
                        end
                    end
                end
                ST_DAT_RISE: begin
                    if (step) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], ee_dout};
                        state_q <= ST_DAT_FALL;
                    end
                end
                ST_DAT_FALL: begin
                    if (step) begin
                        if (bidx_q == DAT_LAST) begin
                            word_data  <= shreg_q;
                            word_valid <= 1'b1;
                            state_q    <= ST_DESEL;
                        end else begin
                            bidx_q  <= bidx_q + 1'b1;
                            state_q <= ST_DAT_RISE;
                        end
                    end
                end
                ST_DESEL: begin
                    if (step) begin
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_DISABLE;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            addr_q  <= addr_q + 1'b1;
                            state_q <= ST_SELECT;
                        end
                    end
                end
                ST_DISABLE: begin
                    if (step) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pin decode from state
    always_comb begin
        busy    = 1'b1;
        link_en = 1'b1;
        ee_cs   = 1'b0;
        ee_sk   = 1'b0;
        ee_di   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                link_en = 1'b0;
            end
            ST_ENABLE, ST_DESEL: ;
            ST_SELECT: ee_cs = 1'b1;
            ST_CMD_SET, ST_CMD_FALL: begin
                ee_cs = 1'b1;
                ee_di = cmd_vec[CMD_LAST - bidx_q];
            end
            ST_CMD_RISE: begin
                ee_cs = 1'b1;
                ee_sk = 1'b1;
                ee_di = cmd_vec[CMD_LAST - bidx_q];
            end
            ST_DAT_RISE: begin
                ee_cs = 1'b1;
                ee_sk = 1'b1;
                ee_di = cmd_vec[0];
            end
            ST_DAT_FALL: begin
                ee_cs = 1'b1;
                ee_di = cmd_vec[0];
            end
            ST_DISABLE: link_en = 1'b0;
            default: begin
                busy    = 1'b0;
                link_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
    parameter int unsigned HALF_CLKS = 4,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CNT_W     = 7,
    parameter int unsigned DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic              busy,
    output logic              link_en,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_dout,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              done
);
    logic step;

    ewr_step_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .step  (step)
    );

    ewr_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .req        (req),
        .start_addr (start_addr),
        .word_cnt   (word_cnt),
        .ee_dout    (ee_dout),
        .busy       (busy),
        .link_en    (link_en),
        .ee_cs      (ee_cs),
        .ee_sk      (ee_sk),
        .ee_di      (ee_di),
        .word_data  (word_data),
        .word_valid (word_valid),
        .done       (done)
    );
endmodule

// File: rtl/ewr_checker.sv
module ewr_checker #(
    parameter int unsigned HALF_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic link_en,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di,
    input logic word_valid,
    input logic done
);
    localparam int unsigned RW = $clog2(HALF_CLKS + 1);
    localparam logic [RW-1:0] RMAX = RW'(HALF_CLKS);

    logic [3:0]    pins;
    logic [3:0]    pins_q;
    logic [RW-1:0] run_q;

    assign pins = {link_en, ee_cs, ee_sk, ee_di};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
            run_q  <= RMAX;
        end else begin
            pins_q <= pins;
            if (pins != pins_q)      run_q <= RW'(1);
            else if (run_q != RMAX)  run_q <= run_q + 1'b1;
        end
    end

    // R3: select edges only with the serial clock low
    p_cs_edge_sk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_cs) |-> !ee_sk);

    // R3: data-in holds while the serial clock is high
    p_di_hold_sk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di));

    // R2: select only inside the enable window
    p_cs_in_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> link_en);

    // R4: word strobe only during a run
    p_valid_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> busy);

    // R4: word strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8: done is a single pulse, with busy low
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: no pin value lasts less than one step
    p_step_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != pins_q) |-> (run_q >= RMAX));
endmodule

bind eeprom_word_reader ewr_checker #(.HALF_CLKS(HALF_CLKS)) u_ewr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .link_en    (link_en),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .word_valid (word_valid),
    .done       (done)
);

// File: tb/eeprom_word_reader_bench.sv
`timescale 1ns/1ps
module eeprom_word_reader_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  start_addr = '0;
    logic [6:0]  word_cnt = '0;
    logic        busy, link_en, ee_cs, ee_sk, ee_di;
    logic        ee_dout = 1'b0;
    logic [15:0] word_data;
    logic        word_valid, done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    eeprom_word_reader u_eeprom_word_reader (
        .clk(clk), .rst_n(rst_n), .req(req), .start_addr(start_addr),
        .word_cnt(word_cnt), .busy(busy), .link_en(link_en), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_dout(ee_dout), .word_data(word_data),
        .word_valid(word_valid), .done(done)
    );

    function automatic logic [15:0] memval(input logic [5:0] a);
        return 16'hC3A5 ^ {a, a[3:0], a};
    endfunction

    // Behavioural EEPROM
    int          m_bits = 0;
    int          m_dbit = 0;
    logic [8:0]  m_sh = '0;
    logic [15:0] m_cur = '0;
    int          m_n = 0;
    logic [2:0]  m_opc [64];
    logic [5:0]  m_adr [64];
    int          proto_err = 0;

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (m_bits < 9) begin
                m_sh = {m_sh[7:0], ee_di};
                m_bits = m_bits + 1;
                if (m_bits == 9 && m_n < 64) begin
                    m_opc[m_n] = m_sh[8:6];
                    m_adr[m_n] = m_sh[5:0];
                    m_cur = memval(m_sh[5:0]);
                    m_n = m_n + 1;
                end
            end else if (m_dbit < 16) begin
                ee_dout = m_cur[15 - m_dbit];
                m_dbit = m_dbit + 1;
            end
        end
    end
    always @(negedge ee_cs) begin
        m_bits = 0;
        m_dbit = 0;
    end
    always @(ee_di) if (ee_sk) proto_err = proto_err + 1;
    always @(posedge ee_cs) if (ee_sk || !link_en) proto_err = proto_err + 1;

    // Output monitor
    logic [15:0] cap [64];
    int cap_n = 0, busy_cyc = 0, done_n = 0, pin_act = 0;
    always @(negedge clk) begin
        if (busy) busy_cyc = busy_cyc + 1;
        if (done) done_n = done_n + 1;
        if (ee_cs || ee_sk || link_en) pin_act = pin_act + 1;
        if (word_valid && cap_n < 64) begin
            cap[cap_n] = word_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; busy_cyc = 0; done_n = 0; m_n = 0; pin_act = 0;
        proto_err = 0;
    endtask

    task automatic t_reset();
        chk(!busy && !link_en && !ee_cs, "R1", "busy/link/cs", {busy, link_en, ee_cs}, 0);
        chk(!ee_sk && !ee_di, "R1", "sk/di", {ee_sk, ee_di}, 0);
        chk(!word_valid && !done, "R1", "valid/done", {word_valid, done}, 0);
    endtask

    task automatic t_read(input logic [5:0] a, input int n, input bit poke);
        clear_mon();
        @(negedge clk);
        req = 1'b1; start_addr = a; word_cnt = 7'(n);
        @(negedge clk);
        req = 1'b0;
        chk(link_en && !ee_cs, "R2", "link_en up before select", {link_en, ee_cs}, 2);
        repeat (HALF) @(negedge clk);
        chk(ee_cs && !ee_sk, "R3", "select with sk low", {ee_cs, ee_sk}, 2);
        if (poke) begin
            repeat (50) @(negedge clk);
            req = 1'b1; start_addr = ~a; word_cnt = 7'd5;
            @(negedge clk);
            req = 1'b0;
        end
        wait (done_n > 0);
        @(negedge clk);
        chk(!done && done_n == 1, "R8", "single done pulse", done_n, 1);
        chk(!link_en && !busy, "R2", "link off after run", {link_en, busy}, 0);
        chk(busy_cyc == (61 * n + 2) * HALF, poke ? "R7" : "R6", "busy cycles",
            busy_cyc, (61 * n + 2) * HALF);
        chk(cap_n == n, poke ? "R7" : "R4", "word count", cap_n, n);
        chk(m_n == n, "R5", "transactions seen", m_n, n);
        chk(proto_err == 0, "R3", "pin ordering errors", proto_err, 0);
        for (int i = 0; i < n && i < 64; i++) begin
            logic [5:0] ea;
            ea = a + 6'(i);
            chk(cap[i] == memval(ea), "R4", "word data", cap[i], memval(ea));
            chk(m_opc[i] == 3'b110, "R3", "opcode", m_opc[i], 6);
            chk(m_adr[i] == ea, poke ? "R7" : "R5", "address", m_adr[i], ea);
        end
    endtask

    task automatic t_zero();
        clear_mon();
        @(negedge clk);
        req = 1'b1; start_addr = 6'd9; word_cnt = 7'd0;
        @(negedge clk);
        req = 1'b0;
        chk(done && !busy, "R9", "done next cycle", {done, busy}, 2);
        @(negedge clk);
        chk(!done, "R9", "done width", done, 0);
        repeat (10) @(negedge clk);
        chk(pin_act == 0 && cap_n == 0, "R9", "pin activity", pin_act, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read(6'd5, 1, 1'b0);
        t_read(6'd10, 4, 1'b0);
        t_read(6'd62, 3, 1'b0);
        t_read(6'd0, 1, 1'b0);
        t_read(6'd20, 2, 1'b1);
        t_zero();
        t_read(6'd63, 1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule